// File: doc/BRIEF.md
# Serial Program Loader with Abbreviated Update

This block receives divider programming words over a three-wire serial link (data, shift clock, enable) and holds them in latches for the divider and phase-detector logic. A frame carries up to 28 bits, sent in this order: a 7-bit swallow word, then a 10-bit main word, then an 11-bit reference word. Each word is sent most significant bit first. A fast system clock oversamples all three serial lines. Each line passes through a synchroniser before any edge is detected.

When enable falls, the latches are updated from the frame. A full 28-bit frame replaces all three words. A short frame of at least 17 bits replaces only the swallow and main words, so the reference word cannot be corrupted by a glitch on the shift clock after a short update. Each falling edge of enable also produces a single-cycle resynchronise strobe for the downstream divider and detector.

Top module: `serial_prog_loader`

## Requirements
- R1: While reset is high, and afterwards until the first load, the swallow word reads 0, the main word reads 3, the reference word reads 3, and both the strobe and the range flag read 0.
- R2: After a frame of exactly 28 shift-clock falls, the outputs take these values. Frame bits 1 to 7 form the swallow word, bits 8 to 17 form the main word, and bits 18 to 28 form the reference word. Each word arrives most significant bit first.
- R3: A data bit is captured at the falling edge of the shift clock. Data changes while the shift clock is high before the fall, or while it is low after the fall, are not captured.
- R4: Shift-clock activity while enable is low changes no latch. It also does not count toward the next frame.
- R5: A frame of 17 to 27 falls updates the swallow and main words from the first 17 bits and leaves the reference word unchanged.
- R6: A frame of fewer than 17 falls leaves all three words unchanged.
- R7: Shift-clock falls after the 28th in one frame are ignored. The loaded values are those of the first 28 bits.
- R8: Every falling edge of enable produces exactly one single-cycle high pulse on the strobe, whatever the frame length.
- R9: A reference value below 3 is still loaded, and the range flag then reads 1. The flag reads 0 whenever the loaded reference value is 3 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock; data is taken on its falling edge |
| ser_en | input | 1 | Frame enable; high opens a frame, and its fall loads the latches |
| a_word | output | 7 | Latched swallow word |
| m_word | output | 10 | Latched main word |
| r_word | output | 11 | Latched reference word |
| sync_pulse | output | 1 | One-cycle resynchronise strobe for the divider and detector |
| r_out_of_range | output | 1 | High while the latched reference word is below 3 |

## Verification
Random frames vary their length across the bands that matter: below 17, exactly 17, between 17 and 28, exactly 28, and beyond 28. Each band has its own update rule, so a mistake in the length decode shows up as a wrong latch value.

In every frame, data is inverted while the shift clock is high and again after it falls, so a design that samples on the wrong edge loads wrong bits. Shift-clock bursts while enable is low reveal a design that counts outside the enable window. Directed reference values of 0, 2 and 3 place the range flag on both sides of its threshold.

// File: rtl/spl_pkg.sv
package spl_pkg;
    localparam int A_W     = 7;
    localparam int M_W     = 10;
    localparam int R_W     = 11;
    localparam int FRAME_W = A_W + M_W + R_W;
    localparam int SHORT_W = A_W + M_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    localparam logic [A_W-1:0] A_RST = '0;
    localparam logic [M_W-1:0] M_RST = M_W'(3);
    localparam logic [R_W-1:0] R_RST = R_W'(3);
    localparam logic [R_W-1:0] R_MIN = R_W'(3);

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [M_W-1:0] m;
        logic [R_W-1:0] r;
    } prog_word_t;

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    function automatic prog_word_t unpack_frame(input frame_t f);
        prog_word_t u;
        u.a = f[FRAME_W-1 -: A_W];
        u.m = f[FRAME_W-1-A_W -: M_W];
        u.r = f[R_W-1:0];
        return u;
    endfunction

    function automatic logic r_in_range(input logic [R_W-1:0] r);
        return r >= R_MIN;
    endfunction

    function automatic prog_word_t reset_word();
        prog_word_t u;
        u.a = A_RST;
        u.m = M_RST;
        u.r = R_RST;
        return u;
    endfunction
endpackage

// File: rtl/spl_sync.sv
module spl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/spl_frame_shift.sv
module spl_frame_shift
    import spl_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   s_data,
    input  logic   s_clk,
    input  logic   s_en,
    output frame_t frame_bits,
    output cnt_t   bit_cnt,
    output logic   load_stb
);
    logic clk_d, en_d;
    logic clk_fall;
    cnt_t wr_idx;

    assign clk_fall = clk_d & ~s_clk;
    assign load_stb = en_d & ~s_en;
    assign wr_idx   = cnt_t'(FRAME_W - 1) - bit_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d      <= 1'b0;
            en_d       <= 1'b0;
            bit_cnt    <= '0;
            frame_bits <= '0;
        end else begin
            clk_d <= s_clk;
            en_d  <= s_en;
            if (!s_en) begin
                bit_cnt <= '0;
            end else if (clk_fall && (bit_cnt < cnt_t'(FRAME_W))) begin
                frame_bits[wr_idx] <= s_data;
                bit_cnt            <= bit_cnt + cnt_t'(1);
            end
        end
    end
endmodule

// File: rtl/spl_latch_bank.sv
module spl_latch_bank
    import spl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_stb,
    input  frame_t     frame_bits,
    input  cnt_t       bit_cnt,
    output prog_word_t prog,
    output logic       sync_pulse,
    output logic       r_bad
);
    prog_word_t incoming;
    logic       take_am, take_r;

    assign incoming = unpack_frame(frame_bits);
    assign take_am  = load_stb && (bit_cnt >= cnt_t'(SHORT_W));
    assign take_r   = load_stb && (bit_cnt == cnt_t'(FRAME_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            prog       <= reset_word();
            sync_pulse <= 1'b0;
            r_bad      <= 1'b0;
        end else begin
            sync_pulse <= load_stb;
            if (take_am) begin
                prog.a <= incoming.a;
                prog.m <= incoming.m;
            end
            if (take_r) begin
                prog.r <= incoming.r;
                r_bad  <= !r_in_range(incoming.r);
            end
        end
    end
endmodule

// File: rtl/serial_prog_loader.sv
module serial_prog_loader
    import spl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ser_data,
    input  logic           ser_clk,
    input  logic           ser_en,
    output logic [A_W-1:0] a_word,
    output logic [M_W-1:0] m_word,
    output logic [R_W-1:0] r_word,
    output logic           sync_pulse,
    output logic           r_out_of_range
);
    logic [2:0] raw_lines, sync_lines;
    frame_t     frame_bits;
    cnt_t       frame_cnt;
    logic       load_stb;
    prog_word_t prog;

    assign raw_lines = {ser_en, ser_clk, ser_data};

    spl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .din (raw_lines),
        .dout(sync_lines)
    );

    spl_frame_shift shift_i (
        .clk       (clk),
        .rst       (rst),
        .s_data    (sync_lines[0]),
        .s_clk     (sync_lines[1]),
        .s_en      (sync_lines[2]),
        .frame_bits(frame_bits),
        .bit_cnt   (frame_cnt),
        .load_stb  (load_stb)
    );

    spl_latch_bank latch_i (
        .clk       (clk),
        .rst       (rst),
        .load_stb  (load_stb),
        .frame_bits(frame_bits),
        .bit_cnt   (frame_cnt),
        .prog      (prog),
        .sync_pulse(sync_pulse),
        .r_bad     (r_out_of_range)
    );

    assign a_word = prog.a;
    assign m_word = prog.m;
    assign r_word = prog.r;
endmodule

// File: rtl/spl_checker.sv
module spl_checker
    import spl_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [A_W-1:0] a_word,
    input logic [M_W-1:0] m_word,
    input logic [R_W-1:0] r_word,
    input logic           sync_pulse,
    input logic           r_out_of_range,
    input cnt_t           frame_cnt
);
    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (a_word == A_RST && m_word == M_RST && r_word == R_RST
                 && !sync_pulse && !r_out_of_range));

    p_r_guard_r5: assert property (@(posedge clk) disable iff (rst)
        (sync_pulse && $past(frame_cnt) != cnt_t'(FRAME_W)) |-> $stable(r_word));

    p_latch_on_sync_r6: assert property (@(posedge clk) disable iff (rst)
        (!$stable(a_word) || !$stable(m_word) || !$stable(r_word)) |-> sync_pulse);

    p_cnt_sat_r7: assert property (@(posedge clk) disable iff (rst)
        frame_cnt <= cnt_t'(FRAME_W));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        sync_pulse |=> !sync_pulse);

    p_flag_tracks_r9: assert property (@(posedge clk) disable iff (rst)
        r_out_of_range == (r_word < R_MIN));
endmodule

bind serial_prog_loader spl_checker chk_i (
    .clk           (clk),
    .rst           (rst),
    .a_word        (a_word),
    .m_word        (m_word),
    .r_word        (r_word),
    .sync_pulse    (sync_pulse),
    .r_out_of_range(r_out_of_range),
    .frame_cnt     (frame_cnt)
);

// File: tb/serial_prog_loader_tb_top.sv
module serial_prog_loader_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_en = 1'b0;
    logic [6:0]  a_word;
    logic [9:0]  m_word;
    logic [10:0] r_word;
    logic sync_pulse, r_out_of_range;

    int total = 0, bad = 0, pulses = 0;
    logic [6:0]  ea = 7'd0;
    logic [9:0]  em = 10'd3;
    logic [10:0] er = 11'd3;

    always #2 clk = ~clk;

    serial_prog_loader dut_i (
        .clk(clk), .rst(rst), .ser_data(ser_data), .ser_clk(ser_clk), .ser_en(ser_en),
        .a_word(a_word), .m_word(m_word), .r_word(r_word),
        .sync_pulse(sync_pulse), .r_out_of_range(r_out_of_range)
    );

    always @(posedge clk) if (!rst && sync_pulse) pulses <= pulses + 1;

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model update from the requirements (R2, R5, R6, R7)
    function automatic void model(input logic [27:0] f, input int n);
        if (n >= 17) begin
            ea = f[27:21];
            em = f[20:11];
        end
        if (n >= 28) er = f[10:0];
    endfunction

    // Bits are inverted around the falling edge, so only a sample taken at the fall is right (R3)
    task automatic send_frame(input logic [27:0] f, input int n);
        ser_en = 1'b1;
        wait_cyc(6);
        for (int i = 0; i < n; i++) begin
            logic b;
            b = (i < 28) ? f[27-i] : 1'($urandom);
            ser_clk = 1'b1; ser_data = ~b; wait_cyc(3);
            ser_data = b;   wait_cyc(3);
            ser_clk = 1'b0; wait_cyc(3);
            ser_data = ~b;  wait_cyc(3);
        end
        ser_en = 1'b0;
        wait_cyc(10);
        model(f, n);
    endtask

    task automatic check_all(input string tag);
        check(a_word == ea, {tag, " swallow"}, a_word, ea);
        check(m_word == em, {tag, " main"}, m_word, em);
        check(r_word == er, {tag, " reference"}, r_word, er);
        check(r_out_of_range == (er < 11'd3), {tag, " flag R9"}, r_out_of_range, er < 11'd3);
    endtask

    task automatic frame_and_check(input logic [27:0] f, input int n, input string tag);
        int p0;
        p0 = pulses;
        send_frame(f, n);
        check_all(tag);
        check(pulses - p0 == 1, "R8 strobe count", pulses - p0, 1);
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int lens [9] = '{5, 16, 17, 22, 27, 28, 28, 28, 33};
        void'($urandom(32'd4242));
        wait_cyc(5);
        check(a_word == 7'd0 && m_word == 10'd3 && r_word == 11'd3, "R1 reset words", r_word, 3);
        check(sync_pulse == 1'b0 && r_out_of_range == 1'b0, "R1 reset strobe/flag", sync_pulse, 0);
        rst = 1'b0;
        wait_cyc(5);
        check_all("R1 after reset");

        frame_and_check({7'h55, 10'h2A3, 11'h5C6}, 28, "R2 R3 full frame");
        frame_and_check({7'h12, 10'h1FF, 11'h000}, 28, "R9 ref zero");
        frame_and_check({7'h7F, 10'h003, 11'h002}, 28, "R9 ref two");
        frame_and_check({7'h01, 10'h100, 11'h003}, 28, "R9 ref three");
        frame_and_check({7'h3C, 10'h0F0, 11'h7FF}, 17, "R5 exact short");
        frame_and_check({7'h2B, 10'h311, 11'h400}, 16, "R6 sixteen");
        frame_and_check(28'h0ABCDEF, 0, "R6 empty");
        frame_and_check({7'h61, 10'h155, 11'h6AA}, 35, "R7 extra clocks");

        // R4: shift clocks with enable low
        for (int i = 0; i < 40; i++) begin
            ser_clk = 1'b1; ser_data = 1'($urandom); wait_cyc(3);
            ser_clk = 1'b0; wait_cyc(3);
        end
        wait_cyc(10);
        check_all("R4 disabled clocks");
        frame_and_check({7'h0E, 10'h2C1, 11'h123}, 17, "R4 fresh count");

        for (int k = 0; k < 40; k++) begin
            logic [27:0] f;
            f = 28'($urandom);
            frame_and_check(f, lens[$urandom % 9], "R2 R5 R6 R7 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule